// File: doc/BRIEF.md
# Dual-Port Bit-Write Synchronous RAM

A behavioural model of a true dual-port synchronous static RAM. Each of the two ports has its own clock, an active-low select, an active-low write strobe, an active-low per-bit write enable, an address, a write-data bus and a registered read-data bus behind an asynchronous active-low output enable. On its own rising edge each port performs a read, a masked write or nothing, independently of the other port.

Storage is built from two banks, one written only by each port. A word is read as the XOR of the two banks. This keeps every array single-writer while both ports write freely. When both ports run from one clock (`SHARED_CLK = 1`), a collision on one address gives a defined result: port 1 wins on the bits both ports write, and a read sees the contents from before the edge.

The read-data register changes only on a read. It holds through writes and idle cycles and starts at zero.

Top module: `dpram_bitmask`

## Requirements
- R1: A rising edge with select low and write strobe low stores each write-data bit whose write-enable bit is 0 into the addressed word.
- R2: During a write, every bit whose write-enable bit is 1 keeps its previous memory value.
- R3: A write with all write-enable bits at 1 changes no memory bit.
- R4: A rising edge with select low and write strobe high loads the addressed word into the port's read-data register, visible after that edge.
- R5: During a write cycle the port's read-data output keeps its previous value.
- R6: With select high, address, write strobe and write data are ignored: memory is unchanged and the read-data output holds its last value.
- R7: While output enable is high the read-data bus is high-impedance, independent of clock and select; when it goes low the held register value reappears.
- R8: Port 2 reads and writes by the same rules as port 1 on its own clock, and each port sees the other port's writes.
- R9: With a shared clock, when both ports write one address on the same edge, port 1's data wins on bits both enable, and bits enabled by only one port take that port's data.
- R10: With a shared clock, a read on one port of the address the other port writes on the same edge returns the contents from before that edge.
- R11: Both read-data registers are zero before the first read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| p1_clk | input | 1 | Port 1 clock |
| p1_sel_n | input | 1 | Port 1 select, active low |
| p1_wr_n | input | 1 | Port 1 write strobe, active low |
| p1_bwr_n | input | WIDTH | Port 1 per-bit write enable, 0 = write bit |
| p1_addr | input | AW | Port 1 word address, AW = log2(WORDS) |
| p1_wdata | input | WIDTH | Port 1 write data |
| p1_oe_n | input | 1 | Port 1 output enable, active low, asynchronous |
| p1_rdata | output | WIDTH | Port 1 read data, tri-state |
| p2_clk | input | 1 | Port 2 clock |
| p2_sel_n | input | 1 | Port 2 select, active low |
| p2_wr_n | input | 1 | Port 2 write strobe, active low |
| p2_bwr_n | input | WIDTH | Port 2 per-bit write enable, 0 = write bit |
| p2_addr | input | AW | Port 2 word address |
| p2_wdata | input | WIDTH | Port 2 write data |
| p2_oe_n | input | 1 | Port 2 output enable, active low, asynchronous |
| p2_rdata | output | WIDTH | Port 2 read data, tri-state |

## Verification
The assertions check on every edge that each port's read register stays put during writes and idle cycles. No property can express what a port stores or returns. The bench's sweeps show the stored values, the per-bit masking, the all-masked no-op and the high-impedance bus. Its same-edge scenarios show the collision priority and old-data reads.

// File: rtl/dpram_bitmask.sv
module dpram_bitmask #(
  parameter int WORDS      = 64,
  parameter int WIDTH      = 16,
  parameter bit SHARED_CLK = 1'b1,
  localparam int AW = $clog2(WORDS)
) (
  input  logic             p1_clk,
  input  logic             p1_sel_n,
  input  logic             p1_wr_n,
  input  logic [WIDTH-1:0] p1_bwr_n,
  input  logic [AW-1:0]    p1_addr,
  input  logic [WIDTH-1:0] p1_wdata,
  input  logic             p1_oe_n,
  output logic [WIDTH-1:0] p1_rdata,
  input  logic             p2_clk,
  input  logic             p2_sel_n,
  input  logic             p2_wr_n,
  input  logic [WIDTH-1:0] p2_bwr_n,
  input  logic [AW-1:0]    p2_addr,
  input  logic [WIDTH-1:0] p2_wdata,
  input  logic             p2_oe_n,
  output logic [WIDTH-1:0] p2_rdata
);

  logic [WIDTH-1:0] bank1 [WORDS];
  logic [WIDTH-1:0] bank2 [WORDS];
  logic [WIDTH-1:0] q1 = '0;
  logic [WIDTH-1:0] q2 = '0;
  logic [WIDTH-1:0] p2_guard;

  wire p1_wr = !p1_sel_n && !p1_wr_n;
  wire p1_rd = !p1_sel_n &&  p1_wr_n;
  wire p2_wr = !p2_sel_n && !p2_wr_n;
  wire p2_rd = !p2_sel_n &&  p2_wr_n;

  generate
    if (SHARED_CLK) begin : g_prio
      assign p2_guard = (p1_wr && p1_addr == p2_addr) ? ~p1_bwr_n : '0;
    end else begin : g_free
      assign p2_guard = '0;
    end
  endgenerate

  wire [WIDTH-1:0] p1_en = ~p1_bwr_n;
  wire [WIDTH-1:0] p2_en = ~p2_bwr_n & ~p2_guard;

  wire [WIDTH-1:0] word1 = bank1[p1_addr] ^ bank2[p1_addr];
  wire [WIDTH-1:0] word2 = bank1[p2_addr] ^ bank2[p2_addr];

  always_ff @(posedge p1_clk) begin
    if (p1_wr)
      bank1[p1_addr] <= (bank1[p1_addr] & ~p1_en) | ((p1_wdata ^ bank2[p1_addr]) & p1_en);
    if (p1_rd)
      q1 <= word1;
  end

  always_ff @(posedge p2_clk) begin
    if (p2_wr)
      bank2[p2_addr] <= (bank2[p2_addr] & ~p2_en) | ((p2_wdata ^ bank1[p2_addr]) & p2_en);
    if (p2_rd)
      q2 <= word2;
  end

  assign p1_rdata = p1_oe_n ? {WIDTH{1'bz}} : q1;
  assign p2_rdata = p2_oe_n ? {WIDTH{1'bz}} : q2;

endmodule

module dpram_bitmask_chk #(
  parameter int WIDTH = 16
) (
  input logic             p1_clk,
  input logic             p1_sel_n,
  input logic             p1_wr_n,
  input logic [WIDTH-1:0] q1,
  input logic             p2_clk,
  input logic             p2_sel_n,
  input logic             p2_wr_n,
  input logic [WIDTH-1:0] q2
);

  AST_P1_WRITE_HOLD: assert property (@(posedge p1_clk) (!p1_sel_n && !p1_wr_n) |=> $stable(q1)); // R5
  AST_P1_IDLE_HOLD:  assert property (@(posedge p1_clk) p1_sel_n |=> $stable(q1)); // R6
  AST_P2_WRITE_HOLD: assert property (@(posedge p2_clk) (!p2_sel_n && !p2_wr_n) |=> $stable(q2)); // R8
  AST_P2_IDLE_HOLD:  assert property (@(posedge p2_clk) p2_sel_n |=> $stable(q2)); // R6

endmodule

bind dpram_bitmask dpram_bitmask_chk #(.WIDTH(WIDTH)) u_chk (
  .p1_clk(p1_clk), .p1_sel_n(p1_sel_n), .p1_wr_n(p1_wr_n), .q1(q1),
  .p2_clk(p2_clk), .p2_sel_n(p2_sel_n), .p2_wr_n(p2_wr_n), .q2(q2)
);

// File: tb/tb_dpram_bitmask.sv
module tb_dpram_bitmask;
  localparam int  W = 8;
  localparam int  N = 16;
  localparam int  A = $clog2(N);
  localparam time TCLK = 10ns;

  logic clk = 1'b0;
  always #(TCLK/2) clk = ~clk;

  logic         s1 = 1'b1, w1 = 1'b1, o1 = 1'b0;
  logic         s2 = 1'b1, w2 = 1'b1, o2 = 1'b0;
  logic [W-1:0] m1 = '1, m2 = '1, d1 = '0, d2 = '0;
  logic [A-1:0] a1 = '0, a2 = '0;
  tri1  [W-1:0] r1, r2;

  int total = 0, bad = 0;
  logic [W-1:0] shadow [N];

  dpram_bitmask #(.WORDS(N), .WIDTH(W), .SHARED_CLK(1'b1)) dut (
    .p1_clk(clk), .p1_sel_n(s1), .p1_wr_n(w1), .p1_bwr_n(m1), .p1_addr(a1),
    .p1_wdata(d1), .p1_oe_n(o1), .p1_rdata(r1),
    .p2_clk(clk), .p2_sel_n(s2), .p2_wr_n(w2), .p2_bwr_n(m2), .p2_addr(a2),
    .p2_wdata(d2), .p2_oe_n(o2), .p2_rdata(r2)
  );

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    s1 = 1'b1; w1 = 1'b1; s2 = 1'b1; w2 = 1'b1;
  endtask

  function automatic logic [W-1:0] pat(input int a);
    return W'(a * 37 + 5);
  endfunction

  initial begin
    #(TCLK * 5000);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    check("R11 p1 start", r1, '0);
    check("R11 p2 start", r2, '0);

    // R1: full writes by port 1, read back by port 2 (R8)
    for (int a = 0; a < N; a++) begin
      s1 = 0; w1 = 0; m1 = '0; a1 = A'(a); d1 = pat(a); shadow[a] = pat(a);
      step();
    end
    for (int a = 0; a < N; a++) begin
      s2 = 0; a2 = A'(a);
      step();
      check("R1/R8 p2 read", r2, shadow[a]);
    end

    // R4 / R5: read then write on port 1, output holds
    s1 = 0; a1 = 3; step();
    check("R4 p1 read", r1, shadow[3]);
    s1 = 0; w1 = 0; m1 = '0; a1 = 3; d1 = 8'hE7; shadow[3] = 8'hE7; step();
    check("R5 p1 hold on write", r1, pat(3));

    // R2: masked writes by port 2, read by port 1
    for (int a = 0; a < N; a++) begin
      logic [W-1:0] mk, nd;
      mk = W'(a * 13 + 1); nd = ~pat(a) ^ W'(a);
      s2 = 0; w2 = 0; m2 = mk; a2 = A'(a); d2 = nd;
      shadow[a] = (shadow[a] & mk) | (nd & ~mk);
      step();
    end
    for (int a = 0; a < N; a++) begin
      s1 = 0; a1 = A'(a); step();
      check("R2 masked write", r1, shadow[a]);
    end

    // R3: all bits masked
    s1 = 0; w1 = 0; m1 = '1; a1 = 5; d1 = ~shadow[5]; step();
    s2 = 0; a2 = 5; step();
    check("R3 all masked no change", r2, shadow[5]);

    // R6: standby ignores inputs
    s1 = 0; a1 = 0; step();
    s1 = 1; w1 = 0; m1 = '0; a1 = 1; d1 = ~shadow[1];
    @(posedge clk); @(negedge clk);
    check("R6 idle hold", r1, shadow[0]);
    w1 = 1;
    s1 = 0; a1 = 1; step();
    check("R6 idle no write", r1, shadow[1]);

    // R7: output enable
    o1 = 1; #1;
    check("R7 high-Z", r1, '1);
    o1 = 0; #1;
    check("R7 re-enable", r1, shadow[1]);

    // R9: same-edge collisions
    s1 = 0; w1 = 0; m1 = 8'hF0; a1 = 9; d1 = 8'hAA;
    s2 = 0; w2 = 0; m2 = 8'h00; a2 = 9; d2 = 8'h55;
    step();
    s1 = 0; a1 = 9; step();
    check("R9 overlap p1 wins", r1, 8'h5A);
    s1 = 0; w1 = 0; m1 = 8'hF0; a1 = 10; d1 = 8'h0C;
    s2 = 0; w2 = 0; m2 = 8'h0F; a2 = 10; d2 = 8'h30;
    step();
    s2 = 0; a2 = 10; step();
    check("R9 disjoint both", r2, 8'h3C);

    // R10: read during other port's write
    s1 = 0; w1 = 0; m1 = '0; a1 = 11; d1 = ~shadow[11];
    s2 = 0; a2 = 11;
    step();
    check("R10 p2 old data", r2, shadow[11]);
    shadow[11] = ~shadow[11];
    s2 = 0; w2 = 0; m2 = '0; a2 = 12; d2 = 8'h3E;
    s1 = 0; a1 = 12;
    step();
    check("R10 p1 old data", r1, shadow[12]);
    s2 = 0; a2 = 11; step();
    check("R10 later new data", r2, shadow[11]);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule